// File: doc/BRIEF.md
# Vector Lane Rotate-and-Merge Unit

This SIMD execution unit operates on 128-bit vectors divided into lanes whose width is picked at run time by a small size code. Every lane of the source vector is rotated left (circular) by one shared count taken from an immediate field. The rotated lane is then blended, bit by bit, into the matching lane of the previous destination contents. A third vector supplies the per-bit select.

An issuing pipeline presents the three vectors, the rotate field and the size code together with a valid strobe. One clock later the unit returns either the merged vector with a result-valid strobe, or an exception flag when the size code is not supported. Register-file ports, decode and memory sit outside the block.

Top module: `vrm_rotmerge_unit`

## Requirements
- R1: A synchronous active-high reset drives out_valid and out_spec_exc low, and out_result to zero.
- R2: An accepted operation (in_valid high, elem_size at most 3) raises out_valid exactly one clock later, with the result on out_result in that same cycle.
- R3: The lane width follows elem_size: code 0 gives 8-bit lanes, 1 gives 16, 2 gives 32 and 3 gives 64, for 128/width lanes. No bit moves from one lane to another.
- R4: Each lane is rotated left circularly, not shifted, by rot_imm AND (lane width - 1). Only the low 3, 4, 5 or 6 bits of rot_imm count, and all lanes use the same count.
- R5: Each result bit is the rotated source bit where mask_vec holds 1, and the old_dst bit where mask_vec holds 0.
- R6: When in_valid is high and elem_size is above 3, out_spec_exc is high one clock later, out_valid stays low, and out_result keeps its previous value.
- R7: A cycle without in_valid leaves out_valid and out_spec_exc low on the next clock, and out_result unchanged.
- R8: A count of zero with an all-ones mask returns src_vec unchanged. An all-zeros mask returns old_dst unchanged, whatever the count.
- R9: Lane 0 sits in bits 127 down to 128-width, the higher-numbered lanes follow toward bit 0, and each output lane is computed from the inputs at the same position.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation strobe |
| elem_size | input | 4 | Lane width code (0..3 legal) |
| rot_imm | input | 6 | Rotate count field |
| old_dst | input | 128 | Previous destination contents |
| src_vec | input | 128 | Vector to be rotated |
| mask_vec | input | 128 | Per-bit select: 1 takes the rotated bit |
| out_valid | output | 1 | Result strobe, one cycle after in_valid |
| out_result | output | 128 | Merged result, held between operations |
| out_spec_exc | output | 1 | Illegal size code flagged |

## Verification
The bench builds the unit with its default parameters: a 128-bit vector, a 6-bit rotate field and a 4-bit size code. The 6-bit field can carry counts up to 63, so every count is masked for the narrow lanes, and the full field is used as-is for 64-bit lanes. With a 4-bit size code, the twelve illegal codes 4 to 15 can all be driven and checked for the exception path. Random operations over every size code, mixed with idle cycles, also test that the result is held between valid operations.

// File: rtl/vrm_pkg.sv
package vrm_pkg;
  localparam int NUM_SIZES  = 4;
  localparam int MIN_LANE_W = 8;
  localparam int MAX_LANE_W = MIN_LANE_W << (NUM_SIZES - 1);
  localparam int ROT_W      = $clog2(MAX_LANE_W);

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_DBL  = 2'd3
  } lane_sz_e;
endpackage

// File: rtl/vrm_size_decode.sv
module vrm_size_decode #(
  parameter int SZ_W = 4
) (
  input  logic [SZ_W-1:0]                 code,
  output logic                            legal,
  output logic [vrm_pkg::NUM_SIZES-1:0]   sel
);
  always_comb begin
    legal = (code < SZ_W'(vrm_pkg::NUM_SIZES));
    sel   = '0;
    for (int s = 0; s < vrm_pkg::NUM_SIZES; s++) begin
      if (code == SZ_W'(s)) sel[s] = 1'b1;
    end
  end
endmodule

// File: rtl/vrm_lane_rotl.sv
module vrm_lane_rotl #(
  parameter int LW = 8,
  localparam int CW = $clog2(LW)
) (
  input  logic [LW-1:0] din,
  input  logic [CW-1:0] cnt,
  output logic [LW-1:0] dout
);
  logic [2*LW-1:0] dbl;
  always_comb begin
    dbl  = {din, din} << cnt;
    dout = dbl[2*LW-1 -: LW];
  end
endmodule

// File: rtl/vrm_rot_slice.sv
module vrm_rot_slice #(
  parameter int VEC_W = 128,
  parameter int LW    = 8,
  localparam int CW    = $clog2(LW),
  localparam int LANES = VEC_W / LW
) (
  input  logic [VEC_W-1:0] src,
  input  logic [CW-1:0]    cnt,
  output logic [VEC_W-1:0] rot
);
  // lane 0 occupies the most significant bits
  for (genvar i = 0; i < LANES; i++) begin : g_lane
    vrm_lane_rotl #(.LW(LW)) u_rot (
      .din  (src[VEC_W-1-i*LW -: LW]),
      .cnt  (cnt),
      .dout (rot[VEC_W-1-i*LW -: LW])
    );
  end
endmodule

// File: rtl/vrm_rotmerge_unit.sv
module vrm_rotmerge_unit #(
  parameter int VEC_W = 128,
  parameter int SZ_W  = 4,
  localparam int ROT_W = vrm_pkg::ROT_W,
  localparam int NSZ   = vrm_pkg::NUM_SIZES
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic [SZ_W-1:0]  elem_size,
  input  logic [ROT_W-1:0] rot_imm,
  input  logic [VEC_W-1:0] old_dst,
  input  logic [VEC_W-1:0] src_vec,
  input  logic [VEC_W-1:0] mask_vec,
  output logic             out_valid,
  output logic [VEC_W-1:0] out_result,
  output logic             out_spec_exc
);
  logic           size_ok;
  logic [NSZ-1:0] size_sel;
  logic [VEC_W-1:0] rot_by_sz [NSZ];
  logic [VEC_W-1:0] rot_pick;
  logic [VEC_W-1:0] merged;

  vrm_size_decode #(.SZ_W(SZ_W)) u_dec (
    .code  (elem_size),
    .legal (size_ok),
    .sel   (size_sel)
  );

  for (genvar s = 0; s < NSZ; s++) begin : g_size
    localparam int LW = vrm_pkg::MIN_LANE_W << s;
    localparam int CW = $clog2(LW);
    vrm_rot_slice #(.VEC_W(VEC_W), .LW(LW)) u_slice (
      .src (src_vec),
      .cnt (rot_imm[CW-1:0]),
      .rot (rot_by_sz[s])
    );
  end

  always_comb begin
    rot_pick = '0;
    for (int s = 0; s < NSZ; s++) begin
      rot_pick = rot_pick | (rot_by_sz[s] & {VEC_W{size_sel[s]}});
    end
    merged = (old_dst & ~mask_vec) | (rot_pick & mask_vec);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid    <= 1'b0;
      out_spec_exc <= 1'b0;
      out_result   <= '0;
    end else begin
      out_valid    <= in_valid & size_ok;
      out_spec_exc <= in_valid & ~size_ok;
      if (in_valid && size_ok) out_result <= merged;
    end
  end
endmodule

// File: rtl/vrm_rotmerge_chk.sv
module vrm_rotmerge_chk #(
  parameter int VEC_W = 128,
  parameter int SZ_W  = 4,
  parameter int ROT_W = 6
) (
  input logic             clk,
  input logic             rst,
  input logic             in_valid,
  input logic [SZ_W-1:0]  elem_size,
  input logic [ROT_W-1:0] rot_imm,
  input logic [VEC_W-1:0] old_dst,
  input logic [VEC_W-1:0] src_vec,
  input logic [VEC_W-1:0] mask_vec,
  input logic             out_valid,
  input logic [VEC_W-1:0] out_result,
  input logic             out_spec_exc
);
  logic legal_in;
  assign legal_in = (elem_size < SZ_W'(4));

  p_latency_r2: assert property (@(posedge clk) disable iff (rst)
    (in_valid && legal_in) |=> (out_valid && !out_spec_exc));

  p_exc_r6: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !legal_in) |=> (out_spec_exc && !out_valid && $stable(out_result)));

  p_idle_r7: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> (!out_valid && !out_spec_exc && $stable(out_result)));

  p_keep_old_r5: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (((out_result ^ $past(old_dst)) & ~$past(mask_vec)) == '0));

  p_passthru_r8: assert property (@(posedge clk) disable iff (rst)
    (in_valid && legal_in && rot_imm == '0 && &mask_vec) |=> (out_result == $past(src_vec)));

  p_exclusive_r6: assert property (@(posedge clk) disable iff (rst)
    !(out_valid && out_spec_exc));
endmodule

bind vrm_rotmerge_unit vrm_rotmerge_chk #(
  .VEC_W(VEC_W), .SZ_W(SZ_W), .ROT_W(ROT_W)
) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .elem_size(elem_size),
  .rot_imm(rot_imm), .old_dst(old_dst), .src_vec(src_vec),
  .mask_vec(mask_vec), .out_valid(out_valid), .out_result(out_result),
  .out_spec_exc(out_spec_exc)
);

// File: tb/sim_vrm_rotmerge_unit.sv
module sim_vrm_rotmerge_unit;
  localparam int VW = 128;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          in_valid = 1'b0;
  logic [3:0]    elem_size = '0;
  logic [5:0]    rot_imm = '0;
  logic [VW-1:0] old_dst = '0, src_vec = '0, mask_vec = '0;
  logic          out_valid, out_spec_exc;
  logic [VW-1:0] out_result;

  int n_chk = 0, n_fail = 0;
  logic [VW-1:0] last_res = '0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  vrm_rotmerge_unit u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .elem_size(elem_size),
    .rot_imm(rot_imm), .old_dst(old_dst), .src_vec(src_vec),
    .mask_vec(mask_vec), .out_valid(out_valid), .out_result(out_result),
    .out_spec_exc(out_spec_exc)
  );

  function automatic logic [VW-1:0] ref_op(logic [VW-1:0] od, logic [VW-1:0] sv,
                                           logic [VW-1:0] mk, logic [5:0] imm,
                                           int sz);
    int w = 8 << sz;
    int c = int'(imm) & (w - 1);
    logic [VW-1:0] rot = '0;
    for (int i = 0; i < VW / w; i++) begin
      int base = VW - (i + 1) * w;
      for (int j = 0; j < w; j++) rot[base + j] = sv[base + ((j - c + w) % w)];
    end
    return (od & ~mk) | (rot & mk);
  endfunction

  task automatic chk(string tag, logic [VW-1:0] act, logic [VW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // drive at posedge+1, sample at the following posedge+1
  task automatic run_op(logic v, int sz, logic [5:0] imm,
                        logic [VW-1:0] od, logic [VW-1:0] sv, logic [VW-1:0] mk);
    logic legal = (sz < 4);
    logic [VW-1:0] exp;
    in_valid = v; elem_size = 4'(sz); rot_imm = imm;
    old_dst = od; src_vec = sv; mask_vec = mk;
    exp = (v && legal) ? ref_op(od, sv, mk, imm, sz) : last_res;
    @(posedge clk); #1;
    in_valid = 1'b0;
    chk("R2/R7 out_valid", {127'd0, out_valid}, {127'd0, v && legal});
    chk("R6 out_spec_exc", {127'd0, out_spec_exc}, {127'd0, v && !legal});
    chk("R3/R4/R5/R6 out_result", out_result, exp);
    last_res = exp;
  endtask

  initial begin
    #400000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [VW-1:0] a, b, m;
    void'($urandom(32'h5eed_0042));
    repeat (3) @(posedge clk);
    #1;
    // R1: reset state
    chk("R1 out_valid", {127'd0, out_valid}, '0);
    chk("R1 out_spec_exc", {127'd0, out_spec_exc}, '0);
    chk("R1 out_result", out_result, '0);
    rst = 1'b0;
    @(posedge clk); #1;

    a = 128'h0123_4567_89ab_cdef_fedc_ba98_7654_3210;
    b = 128'h8001_4002_2004_1008_0810_0420_0240_0180;
    // R3 R4: each size, full mask, nonzero count
    run_op(1, 0, 6'd3, a, b, '1);
    run_op(1, 1, 6'd5, a, b, '1);
    run_op(1, 2, 6'd17, a, b, '1);
    run_op(1, 3, 6'd63, a, b, '1);
    // R4: count wraps by lane width (9 -> 1 for bytes, 20 -> 4 for halves)
    run_op(1, 0, 6'd9, a, b, '1);
    chk("R4 byte count 9 acts as 1", last_res, ref_op(a, b, '1, 6'd1, 0));
    run_op(1, 1, 6'd20, a, b, '1);
    // R5: mixed mask
    run_op(1, 2, 6'd7, a, b, 128'hf0f0_0ff0_ffff_0000_1234_5678_aaaa_5555);
    // R8: pass-through and hold-old
    run_op(1, 3, 6'd0, a, b, '1);
    chk("R8 count 0 all-ones mask", last_res, b);
    run_op(1, 0, 6'd45, a, b, '0);
    chk("R8 zero mask keeps old", last_res, a);
    // R9: distinct lanes, lane 0 at MSB
    run_op(1, 0, 6'd1, '0, 128'h0102_0304_0506_0708_090a_0b0c_0d0e_0f10, '1);
    chk("R9 lane order", last_res, 128'h0204_0608_0a0c_0e10_1214_1618_1a1c_1e20);
    // R6: illegal sizes hold result
    run_op(1, 4, 6'd1, a, b, '1);
    run_op(1, 15, 6'd2, b, a, '1);
    // R7: idle cycle
    run_op(0, 0, 6'd1, b, a, '1);

    for (int k = 0; k < 400; k++) begin
      int r = int'($urandom % 16);
      int sz = (r < 12) ? (r % 4) : (4 + int'($urandom % 12));
      a = {$urandom, $urandom, $urandom, $urandom};
      b = {$urandom, $urandom, $urandom, $urandom};
      m = {$urandom, $urandom, $urandom, $urandom};
      run_op(($urandom % 8) != 0, sz, 6'($urandom), a, b, m);
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule